// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Arrival-Order Arbitration

This block sits between a PWM generator and the gate drivers of a multi-phase bridge. Each phase leg takes two command bits, one for the upper switch and one for the lower switch. It produces two gate enables that are never asserted together. When the commands overlap, the command that was already driving its gate keeps it, and the late arrival is held off. When both commands appear in the same clock cycle, the lower switch is chosen. This fixed choice replaces the simpler approach of blanking the whole leg.

Every gate turn-off starts a programmable dead interval. During that interval both gates of the leg stay off. When the interval ends, the leg arbitrates again from the commands present at that moment. A held-off command therefore gets its gate only after three things have happened: the winner has released, the dead interval has run out, and the held-off command is still asserted.

Each phase also keeps a sticky flag that records any cycle in which both commands were high together. Control software clears the flag with a per-phase clear pulse. The bank holds `NUM_PHASES` identical legs, three by default. Each leg is independent of the others.

Top module: `hbi_interlock_bank`

## Requirements
- R1: In every phase, `hi_gate` and `lo_gate` are never 1 in the same cycle.
- R2: While a phase's `hi_gate` is 1 and its `hi_cmd` stays 1, `hi_gate` stays 1 and `lo_gate` stays 0, whatever `lo_cmd` does.
- R3: While a phase's `lo_gate` is 1 and its `lo_cmd` stays 1, `lo_gate` stays 1 and `hi_gate` stays 0, whatever `hi_cmd` does.
- R4: If both commands are 1 on the same clock edge while the leg is idle, or when its dead interval expires, `lo_gate` turns on and `hi_gate` stays 0.
- R5: A pulse on the losing command while the other gate is on produces no output on the losing side. A gate only rises on an edge where its own command was 1.
- R6: After either gate of a phase falls, both gates of that phase stay 0 for exactly `DEAD_CYC` cycles before any gate of that phase may rise. The default `DEAD_CYC` is 100 cycles, which is 0.5 us at 200 MHz.
- R7: When the dead interval ends, the phase arbitrates again:
  - If only `hi_cmd` is 1, `hi_gate` turns on on the next edge.
  - If only `lo_cmd` is 1, `lo_gate` turns on on the next edge.
  - If neither command is 1, the phase becomes idle.
- R8: When both commands are low, the leg enters the idle state with both gates off. From idle, a single command turns its gate on at the first clock edge that samples it, one cycle of latency.
- R9: The overlap flag `ovl_flag` works as follows:
  - It becomes 1 after any edge that samples both commands of the phase at 1, and it stays 1.
  - A clear pulse `ovl_clr` makes it 0 on the next edge.
  - If the same edge also samples both commands at 1, setting wins over clearing.
- R10: While `rst_n` is 0, all gates and all flags are 0.
- R11: The phases are independent. Commands on one phase never affect the gates or the flag of another phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | NUM_PHASES | Upper-switch command, one bit per phase |
| lo_cmd | input | NUM_PHASES | Lower-switch command, one bit per phase |
| ovl_clr | input | NUM_PHASES | Per-phase clear pulse for the overlap flag |
| hi_gate | output | NUM_PHASES | Upper-switch gate enable, one bit per phase |
| lo_gate | output | NUM_PHASES | Lower-switch gate enable, one bit per phase |
| ovl_flag | output | NUM_PHASES | Sticky overlap indication, one bit per phase |

## Verification
The bench builds the bank with `NUM_PHASES` = 3 and `DEAD_CYC` = 4. A short dead interval lets a few thousand random cycles reach many complete dead-interval expiries. These include expiries where both commands are present, where only the former winner returns, and where neither command is present. Three phases exercise both cross-phase independence and the generate loop at more than one index. The default of 100 cycles is covered only through the checker's saturating gap counters, which accept any `DEAD_CYC`.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

    typedef enum logic [1:0] {
        LEG_IDLE = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2,
        LEG_DEAD = 2'd3
    } leg_state_e;

    typedef struct packed {
        leg_state_e state;
        logic       hi_on;
        logic       lo_on;
    } arb_regs_t;

    typedef struct packed {
        logic seen;
    } flag_regs_t;

endpackage

// File: rtl/hbi_dead_timer.sv
module hbi_dead_timer #(
    parameter int DEAD_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CNT_W = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(DEAD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_regs_t;

    tmr_regs_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (load) begin
            t_d.cnt = RELOAD;
        end else if (t_q.cnt != '0) begin
            t_d.cnt = t_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

    assign done = (t_q.cnt == '0);

endmodule

// File: rtl/hbi_arbiter.sv
module hbi_arbiter
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic dead_done,
    output logic dead_load,
    output logic hi_gate,
    output logic lo_gate
);
    arb_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        dead_load = 1'b0;
        unique case (r_q.state)
            LEG_IDLE: begin
                if (lo_cmd) begin
                    r_d.state = LEG_LOW;
                end else if (hi_cmd) begin
                    r_d.state = LEG_HIGH;
                end
            end
            LEG_HIGH: begin
                if (!hi_cmd) begin
                    r_d.state = LEG_DEAD;
                    dead_load = 1'b1;
                end
            end
            LEG_LOW: begin
                if (!lo_cmd) begin
                    r_d.state = LEG_DEAD;
                    dead_load = 1'b1;
                end
            end
            LEG_DEAD: begin
                if (dead_done) begin
                    if (lo_cmd) begin
                        r_d.state = LEG_LOW;
                    end else if (hi_cmd) begin
                        r_d.state = LEG_HIGH;
                    end else begin
                        r_d.state = LEG_IDLE;
                    end
                end
            end
            default: r_d.state = LEG_IDLE;
        endcase
        r_d.hi_on = (r_d.state == LEG_HIGH);
        r_d.lo_on = (r_d.state == LEG_LOW);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: LEG_IDLE, hi_on: 1'b0, lo_on: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign hi_gate = r_q.hi_on;
    assign lo_gate = r_q.lo_on;

endmodule

// File: rtl/hbi_overlap_flag.sv
module hbi_overlap_flag
    import hbi_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic clr,
    output logic flag
);
    flag_regs_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d.seen = 1'b0;
        end
        if (hi_cmd && lo_cmd) begin
            f_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign flag = f_q.seen;

endmodule

// File: rtl/hbi_leg.sv
module hbi_leg #(
    parameter int DEAD_CYC = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd,
    input  logic ovl_clr,
    output logic hi_gate,
    output logic lo_gate,
    output logic ovl_flag
);
    logic dead_load;
    logic dead_done;

    hbi_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .hi_cmd    (hi_cmd),
        .lo_cmd    (lo_cmd),
        .dead_done (dead_done),
        .dead_load (dead_load),
        .hi_gate   (hi_gate),
        .lo_gate   (lo_gate)
    );

    hbi_dead_timer #(.DEAD_CYC(DEAD_CYC)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (dead_load),
        .done  (dead_done)
    );

    hbi_overlap_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .hi_cmd (hi_cmd),
        .lo_cmd (lo_cmd),
        .clr    (ovl_clr),
        .flag   (ovl_flag)
    );

endmodule

// File: rtl/hbi_interlock_bank.sv
module hbi_interlock_bank #(
    parameter int NUM_PHASES = 3,
    parameter int DEAD_CYC   = 100
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_PHASES-1:0] hi_cmd,
    input  logic [NUM_PHASES-1:0] lo_cmd,
    input  logic [NUM_PHASES-1:0] ovl_clr,
    output logic [NUM_PHASES-1:0] hi_gate,
    output logic [NUM_PHASES-1:0] lo_gate,
    output logic [NUM_PHASES-1:0] ovl_flag
);
    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_leg
        hbi_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .hi_cmd   (hi_cmd[p]),
            .lo_cmd   (lo_cmd[p]),
            .ovl_clr  (ovl_clr[p]),
            .hi_gate  (hi_gate[p]),
            .lo_gate  (lo_gate[p]),
            .ovl_flag (ovl_flag[p])
        );
    end

endmodule

// File: rtl/hbi_checker.sv
module hbi_checker #(
    parameter int NUM_PHASES = 3,
    parameter int DEAD_CYC   = 100
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NUM_PHASES-1:0] hi_cmd,
    input logic [NUM_PHASES-1:0] lo_cmd,
    input logic [NUM_PHASES-1:0] ovl_clr,
    input logic [NUM_PHASES-1:0] hi_gate,
    input logic [NUM_PHASES-1:0] lo_gate,
    input logic [NUM_PHASES-1:0] ovl_flag
);
    localparam int CW = (DEAD_CYC < 2) ? 1 : $clog2(DEAD_CYC + 1);
    localparam logic [CW-1:0] SAT = CW'(DEAD_CYC);

    for (genvar p = 0; p < NUM_PHASES; p++) begin : g_chk
        logic [CW-1:0] hi_off_q, lo_off_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hi_off_q <= SAT;
                lo_off_q <= SAT;
            end else begin
                hi_off_q <= hi_gate[p] ? '0 : ((hi_off_q == SAT) ? SAT : hi_off_q + CW'(1));
                lo_off_q <= lo_gate[p] ? '0 : ((lo_off_q == SAT) ? SAT : lo_off_q + CW'(1));
            end
        end

        AST_GATES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
            !(hi_gate[p] && lo_gate[p])); // R1
        AST_HIGH_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_gate[p] && hi_cmd[p]) |=> (hi_gate[p] && !lo_gate[p])); // R2
        AST_LOW_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
            (lo_gate[p] && lo_cmd[p]) |=> (lo_gate[p] && !hi_gate[p])); // R3
        AST_TIE_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_cmd[p] && lo_cmd[p] && !hi_gate[p]) |=> !hi_gate[p]); // R4
        AST_HIGH_RISE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hi_gate[p]) |-> $past(hi_cmd[p])); // R5
        AST_LOW_RISE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo_gate[p]) |-> $past(lo_cmd[p])); // R5
        AST_LOW_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(lo_gate[p]) |-> (hi_off_q >= SAT)); // R6
        AST_HIGH_AFTER_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(hi_gate[p]) |-> (lo_off_q >= SAT)); // R6
        AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
            (hi_cmd[p] && lo_cmd[p]) |=> ovl_flag[p]); // R9
        AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
            (ovl_clr[p] && !(hi_cmd[p] && lo_cmd[p])) |=> !ovl_flag[p]); // R9
    end

endmodule

bind hbi_interlock_bank hbi_checker #(
    .NUM_PHASES (NUM_PHASES),
    .DEAD_CYC   (DEAD_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_cmd   (hi_cmd),
    .lo_cmd   (lo_cmd),
    .ovl_clr  (ovl_clr),
    .hi_gate  (hi_gate),
    .lo_gate  (lo_gate),
    .ovl_flag (ovl_flag)
);

// File: tb/tb_hbi_interlock_bank.sv
`timescale 1ns/1ps
module tb_hbi_interlock_bank;
    localparam int NP = 3;
    localparam int DC = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] hi_cmd = '0, lo_cmd = '0, ovl_clr = '0;
    logic [NP-1:0] hi_gate, lo_gate, ovl_flag;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // model state: 0 idle, 1 high on, 2 low on, 3 dead interval
    int m_st[NP];
    int m_cnt[NP];
    bit m_flag[NP];

    always #2.5 clk = ~clk;

    hbi_interlock_bank #(.NUM_PHASES(NP), .DEAD_CYC(DC)) dut (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
        .ovl_clr(ovl_clr), .hi_gate(hi_gate), .lo_gate(lo_gate), .ovl_flag(ovl_flag)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic void model_advance(int p, bit h, bit l, bit c);
        case (m_st[p])
            0: if (l) m_st[p] = 2; else if (h) m_st[p] = 1;
            1: if (!h) begin m_st[p] = 3; m_cnt[p] = DC - 1; end
            2: if (!l) begin m_st[p] = 3; m_cnt[p] = DC - 1; end
            default: begin
                if (m_cnt[p] == 0) begin
                    if (l) m_st[p] = 2; else if (h) m_st[p] = 1; else m_st[p] = 0;
                end else begin
                    m_cnt[p]--;
                end
            end
        endcase
        m_flag[p] = (m_flag[p] && !c) || (h && l);
    endfunction

    task automatic step();
        @(posedge clk);
        for (int p = 0; p < NP; p++) model_advance(p, hi_cmd[p], lo_cmd[p], ovl_clr[p]);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            chk("R1 exclusive", int'(hi_gate[p] & lo_gate[p]), 0);
            chk("R7 hi_gate vs model", int'(hi_gate[p]), int'(m_st[p] == 1));
            chk("R7 lo_gate vs model", int'(lo_gate[p]), int'(m_st[p] == 2));
            chk("R9 flag vs model", int'(ovl_flag[p]), int'(m_flag[p]));
        end
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int p = 0; p < NP; p++) begin m_st[p] = 0; m_cnt[p] = 0; m_flag[p] = 0; end
        repeat (3) @(negedge clk);
        chk("R10 hi_gate in reset", int'(hi_gate), 0);
        chk("R10 lo_gate in reset", int'(lo_gate), 0);
        chk("R10 flag in reset", int'(ovl_flag), 0);
        rst_n = 1'b1;
        step();

        // R8: one-cycle latency from idle
        hi_cmd[0] = 1; step();
        chk("R8 hi_gate from idle", hi_gate[0], 1);
        // R2: high first, low arrives later
        lo_cmd[0] = 1; step();
        chk("R2 hi kept", hi_gate[0], 1);
        chk("R2 lo suppressed", lo_gate[0], 0);
        chk("R9 flag set on overlap", ovl_flag[0], 1);
        step();
        chk("R2 hi still kept", hi_gate[0], 1);
        // R5: glitch on losing low command
        lo_cmd[0] = 0; step();
        lo_cmd[0] = 1; step();
        chk("R5 lo glitch gives no output", lo_gate[0], 0);
        // R6/R7: high releases, low waits out dead interval
        hi_cmd[0] = 0;
        for (int k = 0; k < DC; k++) begin
            step();
            chk("R6 lo off during dead", lo_gate[0], 0);
            chk("R6 hi off during dead", hi_gate[0], 0);
        end
        step();
        chk("R7 waiting lo takes gate", lo_gate[0], 1);
        // R9 clear
        ovl_clr[0] = 1; step(); ovl_clr[0] = 0;
        chk("R9 clear", ovl_flag[0], 0);
        // R3: low first, high arrives later
        hi_cmd[0] = 1; step();
        chk("R3 hi suppressed", hi_gate[0], 0);
        chk("R3 lo kept", lo_gate[0], 1);
        ovl_clr[0] = 1; step(); ovl_clr[0] = 0;
        chk("R9 set wins over clear", ovl_flag[0], 1);
        hi_cmd[0] = 0; step(); hi_cmd[0] = 1; step();
        chk("R5 hi glitch gives no output", hi_gate[0], 0);
        // R6 other direction
        lo_cmd[0] = 0;
        for (int k = 0; k < DC; k++) begin
            step();
            chk("R6 hi off during dead", hi_gate[0], 0);
        end
        step();
        chk("R7 waiting hi takes gate", hi_gate[0], 1);
        // R4: simultaneous from idle
        hi_cmd[0] = 0; steps(DC + 2);
        hi_cmd[0] = 1; lo_cmd[0] = 1; step();
        chk("R4 tie lo on", lo_gate[0], 1);
        chk("R4 tie hi off", hi_gate[0], 0);
        // R4 at dead expiry with both present
        lo_cmd[0] = 0; step(); lo_cmd[0] = 1; steps(DC);
        chk("R4 tie at expiry lo on", lo_gate[0], 1);
        chk("R4 tie at expiry hi off", hi_gate[0], 0);
        // R11: independent phases
        hi_cmd = '0; lo_cmd = '0; steps(2 * DC + 2);
        hi_cmd[0] = 1; lo_cmd[1] = 1; step();
        chk("R11 phase0 hi", hi_gate[0], 1);
        chk("R11 phase1 lo", lo_gate[1], 1);
        chk("R11 phase1 hi", hi_gate[1], 0);
        chk("R11 phase2 idle", int'(hi_gate[2] | lo_gate[2]), 0);
        chk("R11 phase2 flag", ovl_flag[2], 0);

        // constrained random section
        for (int n = 0; n < 4000; n++) begin
            for (int p = 0; p < NP; p++) begin
                if ($urandom_range(7) == 0) hi_cmd[p] = ~hi_cmd[p];
                if ($urandom_range(7) == 0) lo_cmd[p] = ~lo_cmd[p];
                ovl_clr[p] = ($urandom_range(15) == 0);
            end
            step();
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule